// File: doc/BRIEF.md
# Two-Phase Horizontal Shift Clock Sequencer

This block produces the digital drive waveforms for the horizontal output register of a CCD image sensor. Every pixel takes four clocks. The sequencer first resets the sense node through the precharge gate. It then releases the gate so the node floats. Next it makes phase one shallow, which dumps the charge of the final register stage onto the node. It finishes with a settle clock that carries a one-clock sample strobe for the downstream sampler. The second phase is always the inverse of the first.

The block runs only while `enable` and the line qualifier `line_act` are both high. When either one is low, the outputs sit at their rest levels: phase one deep, phase two shallow, precharge gate on. A line holds a fixed number of pixels, set by a parameter. After the last pixel, a one-clock end-of-line pulse fires. The sequencer then stays at rest until the qualifier falls and rises again. If the qualifier drops in the middle of a line, the line is abandoned. The next line always starts again from pixel 0, sub-phase 0.

Top module: `hreg_clk_seq`

## Requirements
- R1: `ph2_deep` is always the inverse of `ph1_deep` (1 means the phase is in its deep state).
- R2: While running, each pixel takes four clocks. Sub-phase 0 drives pg=1, ph1_deep=1. Sub-phase 1 drives pg=0, ph1_deep=1. Sub-phase 2 drives pg=0, ph1_deep=0. Sub-phase 3 drives pg=0, ph1_deep=0, sample_stb=1.
- R3: `pg` is low for at least one full clock before `ph1_deep` falls.
- R4: `pg` rises only while `ph1_deep` is 1.
- R5: `sample_stb` is high for exactly one clock per pixel. It is high only while phase one is shallow and `pg` is low, and only after phase one has been shallow for at least one clock.
- R6: In the clock after a rising edge that samples `enable` or `line_act` low, the outputs show the rest levels: pg=1, ph1_deep=1, ph2_deep=0, sample_stb=0. They stay there while the condition lasts.
- R7: In the first clock after `enable` and `line_act` are both sampled high, the outputs show sub-phase 0 of pixel 0. A line that was cut short restarts at pixel 0.
- R8: `eol` is high for one clock. This happens in the clock right after sub-phase 3 of pixel NPIX-1, and only when the line was not cut short.
- R9: After `eol`, the outputs stay at rest levels, with no strobe, until `line_act` has been low for at least one clock.
- R10: While `rst_n` is low, the outputs show the rest levels and `eol` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel sub-phase clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Global run enable |
| line_act | input | 1 | Line-active qualifier |
| pg | output | 1 | Precharge (reset) gate pulse, 1 = on |
| ph1_deep | output | 1 | Phase one, 1 = deep |
| ph2_deep | output | 1 | Phase two, 1 = deep |
| sample_stb | output | 1 | Output level valid strobe |
| eol | output | 1 | One-clock end-of-line pulse |

## Verification
Three patterns drive the main sequence. The first is a full line started from rest. The second is a second line that needs a qualifier fall first, which separates a sequencer that re-arms correctly from one that runs on after end-of-line. The third is a line cut short mid-pixel and then restarted, which shows whether the pixel count really restarts at zero: the end-of-line pulse must come after exactly NPIX fresh pixels. Dropping `enable` on its own checks that both run conditions gate the sequence. Holding the qualifier high after end-of-line checks that no extra pixels leak out.

// File: rtl/hreg_seq_pkg.sv
`timescale 1ns/100ps
package hreg_seq_pkg;
  localparam int SUB_N = 4;
  localparam int SUB_W = $clog2(SUB_N);

  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_RUN = 2'd1, ST_DONE = 2'd2} seq_st_t;

  typedef struct packed {
    logic pg;
    logic h1_deep;
    logic strobe;
  } lvl_t;

  localparam lvl_t REST_LVL = '{pg: 1'b1, h1_deep: 1'b1, strobe: 1'b0};

  // Reset first, isolate, dump charge, then settle with the strobe.
  function automatic lvl_t sub_levels(input logic [SUB_W-1:0] s);
    lvl_t l;
    l.pg      = (s == SUB_W'(0));
    l.h1_deep = (s < SUB_W'(2));
    l.strobe  = (s == SUB_W'(SUB_N - 1));
    return l;
  endfunction
endpackage

// File: rtl/hreg_sub_ctr.sv
`timescale 1ns/100ps
module hreg_sub_ctr
  import hreg_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  output logic [SUB_W-1:0] sub,
  output logic             wrap
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   sub <= '0;
    else if (clr) sub <= '0;
    else          sub <= sub + SUB_W'(1);
  end
  assign wrap = (sub == SUB_W'(SUB_N - 1));
endmodule

// File: rtl/hreg_pix_ctr.sv
`timescale 1ns/100ps
module hreg_pix_ctr #(
  parameter int NPIX = 8,
  localparam int PIX_W = $clog2(NPIX + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic adv,
  output logic last
);
  logic [PIX_W-1:0] pix;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pix <= '0;
    else if (clr) pix <= '0;
    else if (adv) pix <= pix + PIX_W'(1);
  end
  assign last = (pix == PIX_W'(NPIX - 1));
endmodule

// File: rtl/hreg_level_dec.sv
`timescale 1ns/100ps
module hreg_level_dec
  import hreg_seq_pkg::*;
(
  input  logic             active,
  input  logic [SUB_W-1:0] sub,
  output logic             pg,
  output logic             ph1_deep,
  output logic             ph2_deep,
  output logic             stb
);
  lvl_t lv;
  always_comb begin
    lv = active ? sub_levels(sub) : REST_LVL;
    pg       = lv.pg;
    ph1_deep = lv.h1_deep;
    ph2_deep = ~lv.h1_deep;
    stb      = lv.strobe;
  end
endmodule

// File: rtl/hreg_clk_seq.sv
`timescale 1ns/100ps
module hreg_clk_seq
  import hreg_seq_pkg::*;
#(
  parameter int NPIX = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic line_act,
  output logic pg,
  output logic ph1_deep,
  output logic ph2_deep,
  output logic sample_stb,
  output logic eol
);
  seq_st_t          st;
  logic             go, running, sub_wrap, pix_last, line_end;
  logic [SUB_W-1:0] sub;

  assign go       = enable & line_act;
  assign running  = (st == ST_RUN);
  assign line_end = running & go & sub_wrap & pix_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= ST_IDLE;
      eol <= 1'b0;
    end else begin
      eol <= line_end;
      unique case (st)
        ST_IDLE: if (go) st <= ST_RUN;
        ST_RUN: begin
          if (!go)          st <= ST_IDLE;
          else if (line_end) st <= ST_DONE;
        end
        ST_DONE: if (!line_act) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  hreg_sub_ctr u_sub (
    .clk(clk), .rst_n(rst_n), .clr(!running), .sub(sub), .wrap(sub_wrap)
  );

  hreg_pix_ctr #(.NPIX(NPIX)) u_pix (
    .clk(clk), .rst_n(rst_n), .clr(!running), .adv(running & sub_wrap), .last(pix_last)
  );

  hreg_level_dec u_dec (
    .active(running), .sub(sub), .pg(pg), .ph1_deep(ph1_deep),
    .ph2_deep(ph2_deep), .stb(sample_stb)
  );
endmodule

// File: rtl/hreg_clk_seq_chk.sv
`timescale 1ns/100ps
module hreg_clk_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic line_act,
  input logic pg,
  input logic ph1_deep,
  input logic ph2_deep,
  input logic sample_stb,
  input logic eol
);
  a_r1_phases_opposed: assert property (@(posedge clk) disable iff (!rst_n)
    ph1_deep != ph2_deep);
  a_r3_pg_low_before_dump: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ph1_deep) |-> (!pg && !$past(pg)));
  a_r4_pg_rises_deep: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pg) |-> ph1_deep);
  a_r5_strobe_window: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |-> (!pg && !ph1_deep && !$past(ph1_deep)));
  a_r5_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |=> !sample_stb);
  a_r6_rest_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !($past(enable) && $past(line_act)) |-> (pg && ph1_deep && !sample_stb));
  a_r8_eol_after_settle: assert property (@(posedge clk) disable iff (!rst_n)
    eol |-> ($past(sample_stb) && !sample_stb));
  a_r8_eol_single: assert property (@(posedge clk) disable iff (!rst_n)
    eol |=> !eol);
  a_r9_rest_after_eol: assert property (@(posedge clk) disable iff (!rst_n)
    $past(eol) |-> (pg && ph1_deep && !sample_stb));
endmodule

bind hreg_clk_seq hreg_clk_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .line_act(line_act), .pg(pg),
  .ph1_deep(ph1_deep), .ph2_deep(ph2_deep), .sample_stb(sample_stb), .eol(eol)
);

// File: tb/hreg_clk_seq_bench.sv
`timescale 1ns/100ps
module hreg_clk_seq_bench;
  localparam int NPIX = 5;
  // Expected {pg, ph1_deep, sample_stb} for sub-phases 0..3 (R2).
  localparam logic [2:0] EXP_TAB [4] = '{3'b110, 3'b010, 3'b000, 3'b001};
  localparam logic [4:0] REST = 5'b11000; // {pg, ph1, ph2, stb, eol}

  logic clk = 1'b0, rst_n = 1'b0, enable = 1'b0, line_act = 1'b0;
  logic pg, ph1_deep, ph2_deep, sample_stb, eol;
  int n_vec = 0, n_bad = 0;

  hreg_clk_seq #(.NPIX(NPIX)) u_hreg_clk_seq (
    .clk(clk), .rst_n(rst_n), .enable(enable), .line_act(line_act), .pg(pg),
    .ph1_deep(ph1_deep), .ph2_deep(ph2_deep), .sample_stb(sample_stb), .eol(eol)
  );

  always #2.5 clk = ~clk;

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string tag, input logic [4:0] exp);
    logic [4:0] got;
    got = {pg, ph1_deep, ph2_deep, sample_stb, eol};
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %b exp %b", tag, got, exp);
    end
  endtask

  // R1 R2 R3 R4 R5: walk the sub-phase table across a whole line.
  task automatic run_pixels(input string tag, input int npx);
    for (int p = 0; p < npx; p++)
      for (int s = 0; s < 4; s++) begin
        step();
        chk(tag, {EXP_TAB[s][2], EXP_TAB[s][1], ~EXP_TAB[s][1], EXP_TAB[s][0], 1'b0});
      end
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    enable = 1'b1;
    line_act = 1'b1;
    step(); chk("R10 rest in reset", REST);
    step(); chk("R10 rest in reset", REST);
    line_act = 1'b0;
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) begin step(); chk("R6 rest qualifier low", REST); end

    line_act = 1'b1;
    run_pixels("R2 R1 R3 R4 R5 line 1", NPIX);
    step(); chk("R8 eol after last pixel", 5'b11001);
    for (int i = 0; i < 6; i++) begin step(); chk("R9 rest after eol", REST); end

    line_act = 1'b0;
    step(); chk("R6 rest qualifier low", REST);
    line_act = 1'b1;
    run_pixels("R7 line 2 from pixel 0", NPIX);
    step(); chk("R8 eol line 2", 5'b11001);

    line_act = 1'b0;
    step();
    line_act = 1'b1;
    run_pixels("R2 aborted line", 2);
    step(); chk("R2 aborted line sub0", 5'b11000);
    line_act = 1'b0;
    step(); chk("R6 abort rest no eol", REST);
    step(); chk("R6 abort rest no eol", REST);
    line_act = 1'b1;
    run_pixels("R7 restart after abort", NPIX);
    step(); chk("R7 R8 eol after NPIX fresh pixels", 5'b11001);

    line_act = 1'b0;
    step();
    line_act = 1'b1;
    run_pixels("R2 enable test", 1);
    step(); step();
    enable = 1'b0;
    step(); chk("R6 enable low rest", REST);
    step(); chk("R6 enable low rest", REST);
    enable = 1'b1;
    run_pixels("R7 restart after enable", NPIX);
    step(); chk("R8 eol after enable restart", 5'b11001);
    step(); chk("R9 rest after eol", REST);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule